// File: doc/BRIEF.md
# UDP Destination-Port Channel Tagger

This block sits in a receive stream of Ethernet frames. It passes each frame on without changing it and adds a channel number to every beat. The channel comes from the frame's UDP destination port. That port is compared against a small bank of match settings, one per hardware channel, and each setting has its own enable. A frame that hits an enabled setting is tagged with that setting's channel. All other frames are tagged with the default channel, which is one above the last hardware channel and leads to the processor path. A demultiplexer further downstream uses the tag to route the frame.

The UDP port sits deep in the header, so the channel is only known some beats after the frame starts. Incoming beats therefore wait in a word FIFO. When a frame's channel is decided, it goes into a second, parallel FIFO. A beat leaves the block only when both its data and its frame's channel are present. Both streams use valid/ready. The input accepts a beat when `s_valid` and `s_ready` are both high. The output transfers a beat when `m_valid` and `m_ready` are both high. While `m_ready` is low, the output beat and its channel stay unchanged. `s_ready` falls when either store is full. Byte 0 of a frame is carried in bits 31:24 of its first 32-bit word.

Top module: `udp_chan_tagger`

## Requirements
- R1: Data words, start marker, end marker and empty count pass from input to output unchanged and in order, with no beat lost or duplicated.
- R2: A frame is tagged with channel i when three conditions hold. First, its EtherType (bytes 12-13, word 3 bits 31:16) is 0x0800. Second, its IP protocol byte (byte 23, word 5 bits 7:0) is 17. Third, its UDP destination port (bytes 36-37, word 9 bits 31:16) equals match setting i (bits 16*i+15:16*i of `match_port`), with `match_en[i]` high.
- R3: A frame whose port equals no enabled setting is tagged with channel 4.
- R4: A frame whose EtherType is not 0x0800, or whose protocol byte is not 17, is tagged with channel 4, even if its port field equals an enabled setting.
- R5: A frame of fewer than 10 words, which ends before its port field, is tagged with channel 4. A frame of exactly 10 words is still matched.
- R6: A setting whose `match_en` bit is low never produces a hit.
- R7: When several enabled settings equal the port, the lowest-numbered channel wins.
- R8: Every beat of one frame carries the same channel value.
- R9: Back-pressure works on both sides. While `m_valid` is high and `m_ready` is low, all output fields hold steady. The output never holds more beats than the buffer depth. When the buffer is full, `s_ready` is low, so a stalled output stops the input.
- R10: After reset, `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can take an input beat |
| s_data | input | 32 | Input frame word, first byte in bits 31:24 |
| s_sop | input | 1 | First beat of a frame |
| s_eop | input | 1 | Last beat of a frame |
| s_empty | input | 2 | Unused bytes in the last beat |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream takes the output beat |
| m_data | output | 32 | Output frame word |
| m_sop | output | 1 | First beat of a frame |
| m_eop | output | 1 | Last beat of a frame |
| m_empty | output | 2 | Unused bytes in the last beat |
| m_channel | output | 3 | Channel tag for the frame (0-3 hit, 4 default) |
| match_port | input | 64 | Four 16-bit port match settings |
| match_en | input | 4 | Enable per match setting |

## Verification
The assertions assume well-formed input framing: every frame opens with a start-marked beat and closes with an end-marked beat, and no two frames interleave. They also assume the match settings change only while no frame is partway through the header parser. The stimulus builds each frame as a complete word list with markers only on its first and last words. It changes the match settings only after the expected-output queue has drained and the input is idle. Input gaps and output stalls are mixed in, including one long stall that fills the buffer.

// File: rtl/udpch_pkg.sv
package udpch_pkg;
  localparam int WORD_W   = 32;
  localparam int WBYTES   = WORD_W / 8;
  localparam int EMPTY_W  = $clog2(WBYTES);

  // header byte offsets (20-byte IP header assumed)
  localparam int ETYPE_BYTE = 12;
  localparam int PROTO_BYTE = 23;
  localparam int DPORT_BYTE = 36;

  localparam int ETYPE_BEAT = ETYPE_BYTE / WBYTES;
  localparam int PROTO_BEAT = PROTO_BYTE / WBYTES;
  localparam int DPORT_BEAT = DPORT_BYTE / WBYTES;

  localparam int ETYPE_LSB = WORD_W - 8 * (ETYPE_BYTE % WBYTES) - 16;
  localparam int PROTO_LSB = WORD_W - 8 * (PROTO_BYTE % WBYTES) - 8;
  localparam int DPORT_LSB = WORD_W - 8 * (DPORT_BYTE % WBYTES) - 16;

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef struct packed {
    logic               sop;
    logic               eop;
    logic [EMPTY_W-1:0] empty;
    logic [WORD_W-1:0]  data;
  } beat_t;
endpackage

// File: rtl/udpch_fifo.sv
module udpch_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          wr_ok, rd_ok;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, wr_ok} - {{AW{1'b0}}, rd_ok};
    end
  end
endmodule

// File: rtl/udpch_match.sv
module udpch_match #(
  parameter int NCH  = 4,
  parameter int CH_W = 3
) (
  input  logic [15:0]       port,
  input  logic [NCH*16-1:0] match_port,
  input  logic [NCH-1:0]    match_en,
  output logic              hit,
  output logic [CH_W-1:0]   hit_ch
);
  logic [NCH-1:0] eq;

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign eq[g] = match_en[g] && (match_port[g*16 +: 16] == port);
  end

  // scan downward so the lowest channel is the last to write
  always_comb begin
    hit    = 1'b0;
    hit_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit    = 1'b1;
        hit_ch = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/udpch_parse.sv
module udpch_parse
  import udpch_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              sop,
  input  logic              eop,
  input  logic [15:0]       etype_f,
  input  logic [7:0]        proto_f,
  input  logic [15:0]       dport_f,
  input  logic [NCH*16-1:0] match_port,
  input  logic [NCH-1:0]    match_en,
  output logic              dec_push,
  output logic [CH_W-1:0]   dec_ch
);
  localparam int CNT_W = $clog2(DPORT_BEAT + 2);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(DPORT_BEAT + 1);
  localparam logic [CH_W-1:0]  DEF_CH = CH_W'(NCH);

  logic [CNT_W-1:0] cnt_q, idx;
  logic             et_q, pr_q, done_q;
  logic             et_now, pr_now, done_now, at_port;
  logic             hit;
  logic [CH_W-1:0]  hit_ch;

  udpch_match #(.NCH(NCH), .CH_W(CH_W)) u_match (
    .port      (dport_f),
    .match_port(match_port),
    .match_en  (match_en),
    .hit       (hit),
    .hit_ch    (hit_ch)
  );

  always_comb begin
    idx      = sop ? '0 : cnt_q;
    done_now = sop ? 1'b0 : done_q;
    et_now   = (idx == CNT_W'(ETYPE_BEAT)) ? (etype_f == ETYPE_IPV4) : et_q;
    pr_now   = (idx == CNT_W'(PROTO_BEAT)) ? (proto_f == PROTO_UDP)  : pr_q;
    at_port  = (idx == CNT_W'(DPORT_BEAT));
    dec_push = acc && !done_now && (at_port || eop);
    dec_ch   = (at_port && et_now && pr_now && hit) ? hit_ch : DEF_CH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      et_q   <= 1'b0;
      pr_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (acc) begin
      cnt_q  <= (idx == SAT) ? SAT : idx + 1'b1;
      et_q   <= et_now;
      pr_q   <= pr_now;
      done_q <= done_now || dec_push;
    end
  end
endmodule

// File: rtl/udp_chan_tagger.sv
module udp_chan_tagger
  import udpch_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [31:0]               s_data,
  input  logic                      s_sop,
  input  logic                      s_eop,
  input  logic [1:0]                s_empty,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [31:0]               m_data,
  output logic                      m_sop,
  output logic                      m_eop,
  output logic [1:0]                m_empty,
  output logic [$clog2(NCH+1)-1:0]  m_channel,
  input  logic [NCH*16-1:0]         match_port,
  input  logic [NCH-1:0]            match_en
);
  localparam int CH_W = $clog2(NCH + 1);
  localparam int BW   = $bits(beat_t);

  beat_t           in_b, out_b;
  logic            acc, fire;
  logic            d_full, d_empty, c_full, c_empty;
  logic            dec_push;
  logic [CH_W-1:0] dec_ch;

  assign in_b    = '{sop: s_sop, eop: s_eop, empty: s_empty, data: s_data};
  assign s_ready = !d_full && !c_full;
  assign acc     = s_valid && s_ready;
  assign m_valid = !d_empty && !c_empty;
  assign fire    = m_valid && m_ready;

  assign m_data  = out_b.data;
  assign m_sop   = out_b.sop;
  assign m_eop   = out_b.eop;
  assign m_empty = out_b.empty;

  udpch_fifo #(.W(BW), .DEPTH(DEPTH)) u_words (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(acc),
    .wdata(in_b),
    .rd_en(fire),
    .rdata(out_b),
    .full (d_full),
    .empty(d_empty)
  );

  udpch_fifo #(.W(CH_W), .DEPTH(DEPTH)) u_tags (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(dec_push),
    .wdata(dec_ch),
    .rd_en(fire && out_b.eop),
    .rdata(m_channel),
    .full (c_full),
    .empty(c_empty)
  );

  udpch_parse #(.NCH(NCH), .CH_W(CH_W)) u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .sop       (s_sop),
    .eop       (s_eop),
    .etype_f   (s_data[ETYPE_LSB +: 16]),
    .proto_f   (s_data[PROTO_LSB +: 8]),
    .dport_f   (s_data[DPORT_LSB +: 16]),
    .match_port(match_port),
    .match_en  (match_en),
    .dec_push  (dec_push),
    .dec_ch    (dec_ch)
  );
endmodule

// File: rtl/udpch_chk.sv
module udpch_chk #(
  parameter int NCH   = 4,
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     s_valid,
  input logic                     s_ready,
  input logic                     m_valid,
  input logic                     m_ready,
  input logic [31:0]              m_data,
  input logic                     m_sop,
  input logic                     m_eop,
  input logic [1:0]               m_empty,
  input logic [$clog2(NCH+1)-1:0] m_channel
);
  localparam int CH_W = $clog2(NCH + 1);
  localparam int OW   = $clog2(DEPTH + 1) + 1;

  logic [OW-1:0]   occ;
  logic            mid_q;
  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      mid_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      occ <= occ + OW'(s_valid && s_ready) - OW'(m_valid && m_ready);
      if (m_valid && m_ready) begin
        mid_q  <= !m_eop;
        chan_q <= m_channel;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_channel)
      && $stable(m_sop) && $stable(m_eop) && $stable(m_empty)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH)); // R9
  AST_FULL_STOPS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    occ == OW'(DEPTH) |-> !s_ready); // R9
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_channel <= CH_W'(NCH)); // R3
  AST_CHAN_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && mid_q |-> m_channel == chan_q); // R8
  AST_SOP_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !mid_q |-> m_sop); // R1
endmodule

bind udp_chan_tagger udpch_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .m_sop    (m_sop),
  .m_eop    (m_eop),
  .m_empty  (m_empty),
  .m_channel(m_channel)
);

// File: tb/sim_udp_chan_tagger.sv
module sim_udp_chan_tagger;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        s_valid = 1'b0, s_ready, s_sop = 1'b0, s_eop = 1'b0;
  logic [31:0] s_data = '0;
  logic [1:0]  s_empty = '0;
  logic        m_valid, m_ready = 1'b1, m_sop, m_eop;
  logic [31:0] m_data;
  logic [1:0]  m_empty;
  logic [2:0]  m_channel;
  logic [NCH*16-1:0] match_port = '0;
  logic [NCH-1:0]    match_en = '0;

  udp_chan_tagger #(.NCH(NCH), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sop(s_sop), .s_eop(s_eop), .s_empty(s_empty),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sop(m_sop), .m_eop(m_eop), .m_empty(m_empty),
    .m_channel(m_channel),
    .match_port(match_port), .match_en(match_en)
  );

  int checks = 0;
  int errors = 0;
  logic [38:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] fw [0:31];
  int          nb = 0;
  int          ready_mode = 0;
  bit          gaps = 0;
  bit          hold_pend = 0;
  logic [38:0] hold_val = '0;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // behavioural channel choice from the requirements
  function automatic logic [2:0] ref_chan(int n);
    if (n < 10) return 3'd4;
    if (fw[3][31:16] != 16'h0800 || fw[5][7:0] != 8'd17) return 3'd4;
    for (int i = 0; i < NCH; i++)
      if (match_en[i] && match_port[i*16 +: 16] == fw[9][31:16]) return 3'(i);
    return 3'd4;
  endfunction

  task automatic build(int n, logic [15:0] et, logic [7:0] pr, logic [15:0] dp);
    nb = n;
    for (int i = 0; i < n; i++) fw[i] = $urandom;
    if (n > 3) fw[3][31:16] = et;
    if (n > 5) fw[5][7:0] = pr;
    if (n > 9) fw[9][31:16] = dp;
  endtask

  task automatic send(string tag, logic [1:0] emp);
    logic [2:0] ch;
    ch = ref_chan(nb);
    for (int i = 0; i < nb; i++) begin
      exp_q.push_back({ch, i == 0, i == nb - 1, (i == nb - 1) ? emp : 2'd0, fw[i]});
      tag_q.push_back(tag);
    end
    for (int i = 0; i < nb; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        s_valid = 1'b0;
        @(posedge clk); #1;
      end
      s_valid = 1'b1;
      s_data  = fw[i];
      s_sop   = (i == 0);
      s_eop   = (i == nb - 1);
      s_empty = (i == nb - 1) ? emp : 2'd0;
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    s_valid = 1'b0;
    s_sop   = 1'b0;
    s_eop   = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() > 0 && n < 3000) begin
      @(posedge clk); #1;
      n++;
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 frames left in queue: got %0d exp 0", exp_q.size());
    end
  endtask

  // output ready pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        0: m_ready = 1'b1;
        1: m_ready = ($urandom % 2) == 0;
        default: m_ready = 1'b0;
      endcase
    end
  end

  // reference compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [38:0] got;
      got = {m_channel, m_sop, m_eop, m_empty, m_data};
      if (hold_pend) begin
        checks++;
        if (!m_valid || got !== hold_val) begin
          errors++;
          $display("FAIL R9 stall hold: got %h exp %h", got, hold_val);
        end
      end
      hold_pend = m_valid && !m_ready;
      hold_val  = got;
      if (m_valid && m_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected beat: got %h exp none", got);
        end else begin
          logic [38:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL %s beat mismatch: got %h exp %h", t, got, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 reset state: got v=%b r=%b exp v=0 r=1", m_valid, s_ready);
    end
    @(posedge clk); #1;

    match_port = {16'h4000, 16'h3000, 16'h2000, 16'h1000};
    match_en   = 4'b1111;

    build(12, 16'h0800, 8'd17, 16'h2000); send("R2", 2'd0);
    build(10, 16'h0800, 8'd17, 16'h4000); send("R5", 2'd2);
    build(14, 16'h0800, 8'd17, 16'h0000); fw[0] = 32'h0; send("R1", 2'd1);
    build(11, 16'h0800, 8'd17, 16'h5555); send("R3", 2'd0);
    build(12, 16'h86DD, 8'd17, 16'h1000); send("R4", 2'd0);
    build(12, 16'h0800, 8'd6,  16'h1000); send("R4", 2'd3);
    build(9,  16'h0800, 8'd17, 16'h0);    send("R5", 2'd0);
    build(1,  16'h0,    8'd0,  16'h0);    send("R5", 2'd3);
    build(12, 16'h0800, 8'd17, 16'h1000); send("R2", 2'd0);
    drain();

    match_en = 4'b1110;
    build(12, 16'h0800, 8'd17, 16'h1000); send("R6", 2'd0);
    drain();

    match_port = {16'h4000, 16'h2000, 16'h2000, 16'h1000};
    match_en   = 4'b1111;
    build(12, 16'h0800, 8'd17, 16'h2000); send("R7", 2'd0);
    drain();
    match_en = 4'b1101;
    build(12, 16'h0800, 8'd17, 16'h2000); send("R6", 2'd0);
    drain();

    // long stall fills the buffer
    ready_mode = 2;
    build(24, 16'h0800, 8'd17, 16'h4000);
    fork
      send("R9", 2'd0);
      begin
        repeat (40) @(negedge clk);
        checks++;
        if (s_ready !== 1'b0) begin
          errors++;
          $display("FAIL R9 full buffer: got s_ready=%b exp 0", s_ready);
        end
        @(posedge clk); #1;
        ready_mode = 0;
      end
    join
    drain();

    // mixed traffic with gaps and random back-pressure
    ready_mode = 1;
    gaps = 1;
    for (int k = 0; k < 30; k++) begin
      logic [15:0] p;
      case ($urandom % 4)
        0: p = 16'h1000;
        1: p = 16'h3000;
        2: p = 16'h4000;
        default: p = 16'($urandom);
      endcase
      build(1 + int'($urandom % 20), ($urandom % 5 == 0) ? 16'h0806 : 16'h0800,
            ($urandom % 5 == 0) ? 8'd6 : 8'd17, p);
      send("R8", 2'($urandom));
    end
    drain();
    ready_mode = 0;
    repeat (5) @(posedge clk);

    summary();
    $finish;
  end
endmodule